// File: doc/BRIEF.md
# BCD Calendar Clock Register Bank

This block models a byte-wide static memory of 8,192 locations, synchronous to a system clock, whose eight highest addresses form a calendar clock in BCD. A set of hidden BCD counters keeps the time. A one-second strobe (`tick`) stands in for the oscillator. On each strobe a control circuit advances the counters and copies the result into the eight visible clock bytes. Those bytes are ordinary read/write cells, so the host reaches them like any other location.

The host uses an asynchronous-SRAM-style port. It has a 13-bit address, separate data-in and data-out buses with an output-valid flag, an active-low chip enable, an active-high chip enable, an active-low output enable and an active-low write enable. A write takes effect at the clock edge and a read is combinational.

Three control bits change how the copy works:
- A read-hold bit freezes the visible bytes so the host gets a consistent snapshot, while the counters keep running.
- A set-time bit suspends both counting and copying. Clearing it loads the counters from the bytes the host wrote.
- A stop bit halts the counters.

An undervoltage flag (`pwr_fail`) blocks every write to the whole array.

The locations below the clock bytes are backed by `2**SRAM_AW` bytes of storage. With the default of 2,048 bytes, they are mirrored across the lower address space.

Top module: `rtc_sram_bank`

## Requirements
- R1: The clock bytes sit at 0x1FF8 (control), 0x1FF9 (seconds), 0x1FFA (minutes), 0x1FFB (hours), 0x1FFC (day of week), 0x1FFD (date), 0x1FFE (month) and 0x1FFF (year). After reset they read 00,00,00,00,01,01,01,00.
- R2: When the counters advance, they count in BCD. Seconds and minutes wrap 59→00, hours wrap 23→00, month wraps 12→01 and year wraps 99→00. Each wrap carries into the next field in the order seconds, minutes, hours, date, month, year.
- R3: Date wraps to 01 after day 31 of months 01,03,05,07,08,10,12, after day 30 of months 04,06,09,11, and after day 28 of month 02. When the year value is divisible by 4, month 02 wraps after day 29 instead.
- R4: Bits that are not used read as 0. The masks are: control 0xFF, seconds 0xFF, minutes 0x7F, hours 0x3F, day 0x47, date 0x3F, month 0x1F, year 0xFF. Seconds bit 7 (stop) and day bit 6 (frequency test) keep their written value across copies.
- R5: On a cycle with `tick`=1, set-time bit (control bit 7) = 0 and read-hold bit (control bit 6) = 0, the visible time fields show the newly advanced counter value from the next cycle on.
- R6: `dout_en`=1 and `dout` carries the addressed byte exactly when `ce1_n`=0, `ce2`=1, `oe_n`=0 and `we_n`=1. Otherwise `dout_en`=0 and `dout`=0.
- R7: A write takes place at the clock edge when `we_n`=0, `ce1_n`=0 and `ce2`=1. The output stays off during a write cycle even with `oe_n`=0.
- R8: While `pwr_fail`=1, no location changes on a host write. This covers both the storage and the clock bytes.
- R9: While the read-hold bit is 1, ticks do not change the visible bytes, but the counters keep advancing. The first copy after the bit is cleared shows all the elapsed seconds.
- R10: While the set-time bit is 1, the counters neither advance nor copy. A host write to control that clears the bit loads the counters from the visible time fields.
- R11: While the stop bit (seconds bit 7) is 1, the counters do not advance. Ticks still copy the unchanged counter value.
- R12: Day of week counts 1..7 and wraps from 7 to 1 when the hours wrap at midnight.
- R13: Addresses below 0x1FF8 access general storage through their low `SRAM_AW` address bits. With the default of 11, address 0x0805 and address 0x0005 are the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | Read data valid (bus would be driven) |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pwr_fail | input | 1 | Supply out of tolerance; blocks writes |
| tick | input | 1 | One-second strobe, one cycle wide |

## Verification
The counters are preset through the set-time bit to points just before a rollover. Each of these settings separates a different carry path:
- 23:59:58 on day 7, Dec 31 '99 wraps every field at once.
- 23:59:59 on Feb 28 '23 tells a common year apart from a leap year.
- 23:59:59 on Feb 29 '24 covers the leap-year end of February.
- 23:59:59 on Apr 30 covers a 30-day month.

Tick runs are also made with the read-hold bit, set-time bit and stop bit each set in turn. These runs show whether the counters kept running while the display was frozen, or stopped altogether. Host accesses vary the enable combinations, the mirrored storage addresses and `pwr_fail`, so a wrong gate in any one enable or a missing write block shows at the data outputs.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the BCD calendar clock bank.
// Assumes every time value is kept as packed BCD, one byte per field.
package rtc_pkg;

    localparam int CLK_BYTES = 8;

    typedef struct packed {
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] dte;
        logic [7:0] dow;
        logic [7:0] hrs;
        logic [7:0] mins;
        logic [7:0] secs;
    } rtc_time_t;

    localparam rtc_time_t TIME_AT_RESET = '{yr: 8'h00, mon: 8'h01, dte: 8'h01,
                                            dow: 8'h01, hrs: 8'h00, mins: 8'h00,
                                            secs: 8'h00};

    // BCD step with wrap: returns {wrapped, next value}
    function automatic logic [8:0] bcd_next(input logic [7:0] v, input logic [7:0] last,
                                            input logic [7:0] first);
        if (v == last) return {1'b1, first};
        if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
        return {1'b0, v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last date of a month in BCD, leap February when year % 4 == 0
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        logic [6:0] yb;
        yb = {3'b000, yr[7:4]} * 7'd10 + {3'b000, yr[3:0]};
        case (mon)
            8'h02:                      return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // Implemented bits of each clock byte (0 = control .. 7 = year)
    function automatic logic [7:0] field_mask(input int i);
        case (i)
            2: return 8'h7F;
            3: return 8'h3F;
            4: return 8'h47;
            5: return 8'h3F;
            6: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Bits owned by the host that a copy must not overwrite
    function automatic logic [7:0] keep_mask(input int i);
        case (i)
            0: return 8'hFF;
            1: return 8'h80;
            4: return 8'h40;
            default: return 8'h00;
        endcase
    endfunction

    // Value of each clock byte after reset
    function automatic logic [7:0] reset_byte(input int i);
        return (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
    endfunction

    // Pick the time field that lands in clock byte i
    function automatic logic [7:0] time_byte(input rtc_time_t t, input int i);
        case (i)
            1: return t.secs;
            2: return t.mins;
            3: return t.hrs;
            4: return t.dow;
            5: return t.dte;
            6: return t.mon;
            7: return t.yr;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/rtc_sram_store.sv
// General-purpose byte storage behind the host port.
// Assumes one access per cycle; write at the edge, read combinational, no reset.
module rtc_sram_store #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store the host byte on a write cycle
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/rtc_counter.sv
// Hidden BCD time counters with full calendar carry chain.
// Assumes the loaded values are legal BCD; halt blocks advance, load has priority.
module rtc_counter
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      halt,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t cnt,
    output rtc_time_t cnt_next
);
    logic [8:0] st_s, st_m, st_h, st_d, st_mo, st_y;

    // Compute the value one second ahead, carrying field by field
    always_comb begin
        cnt_next = cnt;
        st_m = '0; st_h = '0; st_d = '0; st_mo = '0; st_y = '0;
        st_s = bcd_next(cnt.secs, 8'h59, 8'h00);
        cnt_next.secs = st_s[7:0];
        if (st_s[8]) begin
            st_m = bcd_next(cnt.mins, 8'h59, 8'h00);
            cnt_next.mins = st_m[7:0];
            if (st_m[8]) begin
                st_h = bcd_next(cnt.hrs, 8'h23, 8'h00);
                cnt_next.hrs = st_h[7:0];
                if (st_h[8]) begin
                    cnt_next.dow = (cnt.dow == 8'h07) ? 8'h01 : cnt.dow + 8'h01;
                    st_d = bcd_next(cnt.dte, month_last(cnt.mon, cnt.yr), 8'h01);
                    cnt_next.dte = st_d[7:0];
                    if (st_d[8]) begin
                        st_mo = bcd_next(cnt.mon, 8'h12, 8'h01);
                        cnt_next.mon = st_mo[7:0];
                        if (st_mo[8]) begin
                            st_y = bcd_next(cnt.yr, 8'h99, 8'h00);
                            cnt_next.yr = st_y[7:0];
                        end
                    end
                end
            end
        end
    end

    // Hold, load from host bytes, or advance on the one-second strobe
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= TIME_AT_RESET;
        else if (load)           cnt <= load_val;
        else if (tick && !halt)  cnt <= cnt_next;
    end

    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !load) |=> $stable(cnt));

    assert_load_take_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/rtc_clock_regs.sv
// The eight visible clock bytes: host-writable cells refreshed by copies.
// Assumes host write and copy may coincide; the host write wins for its byte.
module rtc_clock_regs
    import rtc_pkg::*;
#(
    parameter int NBYTES = CLK_BYTES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NBYTES)-1:0] wr_sel,
    input  logic [7:0]                wr_data,
    input  logic                      copy_en,
    input  rtc_time_t                 copy_val,
    input  logic [$clog2(NBYTES)-1:0] rd_sel,
    output logic [7:0]                rd_data,
    output logic [7:0]                ctrl,
    output rtc_time_t                 shown,
    output logic                      stop_bit
);
    localparam int SEL_W = $clog2(NBYTES);

    logic [7:0]          bank [NBYTES];
    logic [8*NBYTES-1:0] flat;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        logic [7:0] q;

        // One clock byte: host write first, otherwise copy keeping host bits
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= reset_byte(g);
            else if (wr_en && wr_sel == SEL_W'(g))
                q <= wr_data & field_mask(g);
            else if (copy_en && g != 0)
                q <= (q & keep_mask(g)) | time_byte(copy_val, g);
        end

        assign bank[g]           = q;
        assign flat[8*g +: 8]    = q;

        assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((q & ~field_mask(g)) == 8'h00));
    end

    assign rd_data    = bank[rd_sel];
    assign ctrl       = bank[0];
    assign stop_bit   = bank[1][7];
    assign shown.secs = bank[1] & 8'h7F;
    assign shown.mins = bank[2];
    assign shown.hrs  = bank[3];
    assign shown.dow  = bank[4] & 8'h07;
    assign shown.dte  = bank[5];
    assign shown.mon  = bank[6];
    assign shown.yr   = bank[7];

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !copy_en) |=> $stable(flat));
endmodule

// File: rtl/rtc_sram_bank.sv
// Top: byte-wide memory with a BCD calendar clock in its top eight bytes.
// Assumes tick is a one-cycle strobe per second; pwr_fail blocks all writes.
module rtc_sram_bank
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int SRAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              pwr_fail,
    input  logic              tick
);
    localparam int SEL_W = $clog2(CLK_BYTES);

    logic       chip_on, wr_cyc, is_clk;
    logic       wbit, rbit, stop_bit, load, halt, copy_en;
    logic [7:0] ctrl, clk_rd, ram_rd;
    rtc_time_t  cnt, cnt_next, shown, copy_val;

    assign chip_on = !ce1_n && ce2;
    assign wr_cyc  = chip_on && !we_n && !pwr_fail;
    assign is_clk  = &addr[ADDR_W-1:SEL_W];
    assign dout_en = chip_on && we_n && !oe_n;
    assign dout    = dout_en ? (is_clk ? clk_rd : ram_rd) : 8'h00;

    assign wbit     = ctrl[7];
    assign rbit     = ctrl[6];
    assign load     = wr_cyc && is_clk && addr[SEL_W-1:0] == '0 && !din[7] && wbit;
    assign halt     = stop_bit || wbit;
    assign copy_en  = tick && !rbit && !wbit;
    assign copy_val = stop_bit ? cnt : cnt_next;

    rtc_sram_store #(.AW(SRAM_AW), .DW(8)) u_store (
        .clk   (clk),
        .we    (wr_cyc && !is_clk),
        .addr  (addr[SRAM_AW-1:0]),
        .wdata (din),
        .rdata (ram_rd)
    );

    rtc_counter u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .halt     (halt),
        .load     (load),
        .load_val (shown),
        .cnt      (cnt),
        .cnt_next (cnt_next)
    );

    rtc_clock_regs #(.NBYTES(CLK_BYTES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_cyc && is_clk),
        .wr_sel   (addr[SEL_W-1:0]),
        .wr_data  (din),
        .copy_en  (copy_en),
        .copy_val (copy_val),
        .rd_sel   (addr[SEL_W-1:0]),
        .rd_data  (clk_rd),
        .ctrl     (ctrl),
        .shown    (shown),
        .stop_bit (stop_bit)
    );

    assert_pf_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail && !tick) |=> ($stable(ctrl) && $stable(shown) && $stable(stop_bit)));

    assert_copy_shows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !rbit && !wbit && !(wr_cyc && is_clk)) |=> (shown == $past(copy_val)));
endmodule

// File: tb/rtc_sram_bank_test.sv
`timescale 1ns/1ps
module rtc_sram_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en;
    logic        ce1_n = 1'b1, ce2 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic        pwr_fail = 1'b0, tick = 1'b0;

    always #4 clk = ~clk;

    rtc_sram_bank uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
        .dout_en(dout_en), .ce1_n(ce1_n), .ce2(ce2), .oe_n(oe_n), .we_n(we_n),
        .pwr_fail(pwr_fail), .tick(tick)
    );

    int    total = 0, bad = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    // Reference model: visible bytes, binary counters, sparse storage
    logic [7:0] vis [8];
    int cs, cm, ch, cdw, cdt, cmo, cy;
    logic [7:0] mem [int];

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] used_bits(input int i);
        case (i)
            2: return 8'h7F;
            3: return 8'h3F;
            4: return 8'h47;
            5: return 8'h3F;
            6: return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) vis[i] = (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
        cs = 0; cm = 0; ch = 0; cdw = 1; cdt = 1; cmo = 1; cy = 0;
    endtask

    task automatic model_edge();
        bit wr, isc, wb, rb, st, ld;
        int idx;
        wr  = !we_n && !ce1_n && ce2 && !pwr_fail;
        isc = addr >= 13'h1FF8;
        idx = int'(addr) - 'h1FF8;
        wb  = vis[0][7]; rb = vis[0][6]; st = vis[1][7];
        ld  = wr && isc && idx == 0 && !din[7] && wb;
        if (ld) begin
            cs = from_bcd(vis[1] & 8'h7F); cm = from_bcd(vis[2]); ch = from_bcd(vis[3]);
            cdw = int'(vis[4][2:0]); cdt = from_bcd(vis[5]); cmo = from_bcd(vis[6]);
            cy = from_bcd(vis[7]);
        end else if (tick && !st && !wb) begin
            cs++;
            if (cs == 60) begin
                cs = 0; cm++;
                if (cm == 60) begin
                    cm = 0; ch++;
                    if (ch == 24) begin
                        ch = 0;
                        cdw = (cdw == 7) ? 1 : cdw + 1;
                        cdt++;
                        if (cdt > days_in(cmo, cy)) begin
                            cdt = 1; cmo++;
                            if (cmo == 13) begin cmo = 1; cy = (cy + 1) % 100; end
                        end
                    end
                end
            end
        end
        if (tick && !rb && !wb) begin
            vis[1] = {vis[1][7], 7'(to_bcd(cs))};
            vis[2] = to_bcd(cm);
            vis[3] = to_bcd(ch);
            vis[4] = {1'b0, vis[4][6], 3'b000, 3'(cdw)};
            vis[5] = to_bcd(cdt);
            vis[6] = to_bcd(cmo);
            vis[7] = to_bcd(cy);
        end
        if (wr) begin
            if (isc) vis[idx] = din & used_bits(idx);
            else     mem[int'(addr) % 2048] = din;
        end
    endtask

    task automatic check_outputs();
        bit         exp_en;
        logic [7:0] exp_d;
        int         k;
        exp_en = !ce1_n && ce2 && !oe_n && we_n;
        exp_d  = 8'h00;
        k      = int'(addr) % 2048;
        if (exp_en) begin
            if (addr >= 13'h1FF8) exp_d = vis[int'(addr) - 'h1FF8];
            else if (mem.exists(k)) exp_d = mem[k];
            else return;
        end
        total++;
        if (dout_en !== exp_en || dout !== exp_d) begin
            bad++;
            $display("FAIL %s addr=%h: dout_en=%0b dout=%h, expected dout_en=%0b dout=%h",
                     cur_tag, addr, dout_en, dout, exp_en, exp_d);
        end
    endtask

    // One bus cycle: compare before the edge, advance the model at the edge
    task automatic step();
        #2;
        check_outputs();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic bus_idle();
        ce1_n = 1'b1; ce2 = 1'b0; oe_n = 1'b1; we_n = 1'b1; tick = 1'b0;
    endtask

    task automatic wr(input logic [12:0] a, input logic [7:0] d);
        addr = a; din = d; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b0; oe_n = 1'b0;
        step(); bus_idle();
    endtask

    task automatic rd(input logic [12:0] a);
        addr = a; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
        step(); bus_idle();
    endtask

    task automatic probe(input logic c1, input logic c2, input logic oe, input logic we);
        addr = 13'h0005; din = 8'hEE; ce1_n = c1; ce2 = c2; oe_n = oe; we_n = we;
        step(); bus_idle();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; addr = 13'h1FF9; ce1_n = 1'b0; ce2 = 1'b1; we_n = 1'b1; oe_n = 1'b0;
            step(); bus_idle();
            rd(13'h1FF9);
        end
    endtask

    task automatic show_clock();
        for (int i = 0; i < 8; i++) rd(13'h1FF8 + 13'(i));
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] dw, input logic [7:0] dt, input logic [7:0] mo,
                            input logic [7:0] y);
        wr(13'h1FF8, 8'h80);
        wr(13'h1FF9, s); wr(13'h1FFA, m); wr(13'h1FFB, h); wr(13'h1FFC, dw);
        wr(13'h1FFD, dt); wr(13'h1FFE, mo); wr(13'h1FFF, y);
        wr(13'h1FF8, 8'h00);
    endtask

    initial begin
        model_reset();
        bus_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";  show_clock();

        cur_tag = "R7";  wr(13'h0005, 8'hA5); rd(13'h0005); wr(13'h0123, 8'h3C); rd(13'h0123);
        cur_tag = "R13"; wr(13'h0805, 8'h5A); rd(13'h0005); wr(13'h1FF7, 8'h77); rd(13'h07F7);
        cur_tag = "R6";
        probe(1'b0, 1'b1, 1'b1, 1'b1);
        probe(1'b1, 1'b1, 1'b0, 1'b1);
        probe(1'b0, 1'b0, 1'b0, 1'b1);
        probe(1'b0, 1'b1, 1'b0, 1'b1);

        cur_tag = "R8";
        pwr_fail = 1'b1;
        wr(13'h0005, 8'hFF); wr(13'h1FFA, 8'h33); wr(13'h1FF8, 8'h80);
        rd(13'h0005); rd(13'h1FFA); rd(13'h1FF8);
        pwr_fail = 1'b0;

        cur_tag = "R4";
        wr(13'h1FF8, 8'h80);
        wr(13'h1FFB, 8'hE3); wr(13'h1FFC, 8'hF2); wr(13'h1FFE, 8'hF2); wr(13'h1FFA, 8'hD5);
        wr(13'h1FF8, 8'h00);
        show_clock();
        ticks(1); show_clock();

        cur_tag = "R2";  set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        ticks(2);
        cur_tag = "R12"; show_clock();

        cur_tag = "R3";
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23); ticks(1); show_clock();
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24); ticks(1); show_clock();
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24); ticks(1); show_clock();
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24); ticks(1); show_clock();

        cur_tag = "R5";  set_time(8'h10, 8'h20, 8'h05, 8'h02, 8'h15, 8'h06, 8'h30);
        ticks(3); show_clock();

        cur_tag = "R9";
        wr(13'h1FF8, 8'h40); ticks(3); show_clock();
        wr(13'h1FF8, 8'h00); ticks(1); show_clock();

        cur_tag = "R10";
        wr(13'h1FF8, 8'h80); ticks(2); wr(13'h1FF9, 8'h45); ticks(1);
        wr(13'h1FF8, 8'h00); rd(13'h1FF9); ticks(1); show_clock();

        cur_tag = "R11";
        wr(13'h1FF9, 8'h80); ticks(3); show_clock();
        wr(13'h1FF9, 8'h00); ticks(2); show_clock();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule